// File: doc/BRIEF.md
# Option Byte Register Controller

This block keeps the device option settings: a small set of user option bits, a read-protection level, and one write-protect bit per flash sector. Software reaches it over a simple 32-bit register port. Four word slots are decoded: a key slot, an option control word, a second protection word for the upper sector group, and a status word that carries the busy flag. Writes to the option fields are refused until a two-word key sequence has been written to the key slot. One wrong key locks the register until the next reset.

Software stages new values in the control words and then writes the start bit. The block raises busy for a fixed, parameterised number of cycles. When busy falls it copies the staged values into the committed set. Only the committed set drives the per-sector protect outputs and the read-protection flag seen by the flash sequencer. The non-volatile store is modelled as a register that reloads factory defaults on reset: all sectors unprotected, read protection open, all user bits set.

Top module: `opt_ctrl`

## Requirements
- R1: After reset the register is locked. Busy is low. Every sector output is 1 (unprotected), the read-protect flag is low and the user output is 0xEC. The control word reads 0x0FFFAAED, the second word reads 0x0FFF0000 and the status word reads 0.
- R2: A write of 0x08192A3B followed by a write of 0x4C5D6E7F to the key slot (address 0) clears the lock bit, which is control word bit 0.
- R3: A key write that does not match the expected word, in either position, leaves the register locked until reset. A correct sequence written afterwards does not unlock it.
- R4: While locked, writes to the control word (address 1) and the second word (address 2) change no readback value, and a start request raises no busy.
- R5: An unlocked write to the control word stages the user bits as wdata[7:0] AND 0xEC, the read-protect level from wdata[15:8] and sectors 0 to 11 from wdata[27:16]. An unlocked write to the second word stages sectors 12 to 23 from wdata[27:16]. All other bits read back as 0.
- R6: Staged values that have not been committed leave the sector, read-protect and user outputs unchanged.
- R7: A control write with bit 1 set and bit 0 clear starts a commit. busy_o and status bit 16 stay high for exactly COMMIT_CYCLES cycles. Control bit 1 reads 1 during that time and 0 afterwards. When busy falls the outputs take the staged values.
- R8: Writes to the control word or the second word while busy are ignored.
- R9: rdp_active_o is low only when the committed read-protect level equals 0xAA.
- R10: An unlocked control write with bit 0 set locks the register again and starts no commit. A fresh correct key sequence unlocks it once more.
- R11: sect_wp_n_o bit i is 1 when sector i is unprotected and 0 when it is protected. Bits 11:0 come from the control word and bits 23:12 come from the second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Word slot: 0 key, 1 control, 2 second protection, 3 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed slot (combinational) |
| busy_o | output | 1 | Commit in progress |
| sect_wp_n_o | output | NSEC | Committed per-sector protect, 1 = unprotected |
| rdp_active_o | output | 1 | Committed read protection is active |
| user_opt_o | output | 8 | Committed user option bits |

## Verification
The bench targets several corner cases:
- A bad key in the second position. A design that only checks the first key, or that lets a later good pair recover, unlocks when it must not.
- Staging before a commit. A design that forwards staged fields straight to the outputs shows new protection without any commit.
- The busy window, counted cycle by cycle. An off-by-one counter makes it one cycle too short or too long.
- A second-word write made during busy. It must not leak into the commit, which also separates the two sector halves.
- A write with both lock and start set. It must relock and must not start a commit.

// File: rtl/opt_ctrl_pkg.sv
package opt_ctrl_pkg;
  localparam logic [31:0] OPT_KEY_A = 32'h0819_2A3B;
  localparam logic [31:0] OPT_KEY_B = 32'h4C5D_6E7F;
  localparam logic [7:0]  USER_MASK = 8'hEC;
  localparam logic [7:0]  RDP_OPEN  = 8'hAA;
  localparam int LOCK_BIT  = 0;
  localparam int START_BIT = 1;
  localparam int RDP_LSB   = 8;
  localparam int WP_LSB    = 16;
  localparam int BUSY_BIT  = 16;
  localparam logic [1:0] A_KEY   = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_CTRL2 = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN, KS_DEAD} key_st_e;
endpackage

// File: rtl/opt_key_fsm.sv
module opt_key_fsm
  import opt_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_we_i,
  input  logic [31:0] key_i,
  input  logic        relock_i,
  output logic        locked_o,
  output logic        dead_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_LOCKED: if (key_we_i) st_d = (key_i == OPT_KEY_A) ? KS_HALF : KS_DEAD;
      KS_HALF:   if (key_we_i) st_d = (key_i == OPT_KEY_B) ? KS_OPEN : KS_DEAD;
      KS_OPEN:   if (relock_i) st_d = KS_LOCKED;
      KS_DEAD:   st_d = KS_DEAD;
      default:   st_d = KS_DEAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= KS_LOCKED;
    else         st_q <= st_d;

  assign locked_o = (st_q != KS_OPEN);
  assign dead_o   = (st_q == KS_DEAD);
endmodule

// File: rtl/opt_commit_timer.sv
module opt_commit_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= LOAD;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/opt_ctrl.sv
module opt_ctrl
  import opt_ctrl_pkg::*;
#(
  parameter int SECT_PER_REG  = 12,
  parameter bit DUAL_BANK     = 1'b1,
  parameter int COMMIT_CYCLES = 8,
  localparam int NSEC         = DUAL_BANK ? 2 * SECT_PER_REG : SECT_PER_REG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_we_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic            busy_o,
  output logic [NSEC-1:0] sect_wp_n_o,
  output logic            rdp_active_o,
  output logic [7:0]      user_opt_o
);
  localparam int WP_MSB = WP_LSB + SECT_PER_REG - 1;

  logic locked, key_dead, busy, done;
  logic ctrl_wr, ctrl2_wr, relock, start;

  logic [7:0]      stg_user, nv_user;
  logic [7:0]      stg_rdp, nv_rdp;
  logic [NSEC-1:0] stg_wp, nv_wp;

  assign ctrl_wr  = bus_we_i && (bus_addr_i == A_CTRL) && !locked && !busy;
  assign ctrl2_wr = DUAL_BANK && bus_we_i && (bus_addr_i == A_CTRL2) && !locked && !busy;
  assign relock   = ctrl_wr && bus_wdata_i[LOCK_BIT];
  assign start    = ctrl_wr && bus_wdata_i[START_BIT] && !bus_wdata_i[LOCK_BIT];

  opt_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_we_i (bus_we_i && (bus_addr_i == A_KEY)),
    .key_i    (bus_wdata_i),
    .relock_i (relock),
    .locked_o (locked),
    .dead_o   (key_dead)
  );

  opt_commit_timer #(.CYCLES(COMMIT_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  // staging set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_user <= USER_MASK;
      stg_rdp  <= RDP_OPEN;
      stg_wp   <= '1;
    end else begin
      if (ctrl_wr) begin
        stg_user                 <= bus_wdata_i[7:0] & USER_MASK;
        stg_rdp                  <= bus_wdata_i[RDP_LSB +: 8];
        stg_wp[SECT_PER_REG-1:0] <= bus_wdata_i[WP_MSB:WP_LSB];
      end
      if (ctrl2_wr)
        stg_wp[NSEC-1 -: SECT_PER_REG] <= bus_wdata_i[WP_MSB:WP_LSB];
    end
  end

  // committed set, reloaded with defaults on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_user <= USER_MASK;
      nv_rdp  <= RDP_OPEN;
      nv_wp   <= '1;
    end else if (done) begin
      nv_user <= stg_user;
      nv_rdp  <= stg_rdp;
      nv_wp   <= stg_wp;
    end
  end

  logic [31:0] ctrl2_rd;
  generate
    if (DUAL_BANK) begin : g_dual
      always_comb begin
        ctrl2_rd = '0;
        ctrl2_rd[WP_MSB:WP_LSB] = stg_wp[NSEC-1 -: SECT_PER_REG];
      end
    end else begin : g_single
      assign ctrl2_rd = '0;
    end
  endgenerate

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[7:0]           = stg_user;
        bus_rdata_o[LOCK_BIT]      = locked;
        bus_rdata_o[START_BIT]     = busy;
        bus_rdata_o[RDP_LSB +: 8]  = stg_rdp;
        bus_rdata_o[WP_MSB:WP_LSB] = stg_wp[SECT_PER_REG-1:0];
      end
      A_CTRL2: bus_rdata_o = ctrl2_rd;
      A_STAT:  bus_rdata_o[BUSY_BIT] = busy;
      default: bus_rdata_o = '0;
    endcase
  end

  assign busy_o       = busy;
  assign sect_wp_n_o  = nv_wp;
  assign rdp_active_o = (nv_rdp != RDP_OPEN);
  assign user_opt_o   = nv_user;
endmodule

// File: rtl/opt_ctrl_chk.sv
module opt_ctrl_chk
  import opt_ctrl_pkg::*;
#(
  parameter int NSEC          = 24,
  parameter int COMMIT_CYCLES = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bus_we_i,
  input logic [1:0]      bus_addr_i,
  input logic [31:0]     bus_wdata_i,
  input logic            busy_o,
  input logic [NSEC-1:0] sect_wp_n_o,
  input logic            rdp_active_o,
  input logic [7:0]      user_opt_o,
  input logic            locked_i,
  input logic            dead_i
);
  localparam int BW = $clog2(COMMIT_CYCLES + 2);
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;

  assert_unlock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_i) |-> $past(bus_we_i && bus_addr_i == A_KEY && bus_wdata_i == OPT_KEY_B));

  assert_dead_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_i |=> (dead_i && locked_i));

  assert_locked_no_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && !busy_o) |=> !busy_o);

  assert_outputs_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> ($stable(sect_wp_n_o) && $stable(rdp_active_o) && $stable(user_opt_o)));

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= BW'(COMMIT_CYCLES));

  assert_busy_exact_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(busy_run) == BW'(COMMIT_CYCLES - 1)));

  assert_busy_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(bus_we_i && bus_addr_i == A_CTRL && bus_wdata_i[START_BIT]
                            && !bus_wdata_i[LOCK_BIT]));

  assert_no_lock_change_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !$rose(locked_i));
endmodule

bind opt_ctrl opt_ctrl_chk #(.NSEC(NSEC), .COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .busy_o       (busy_o),
  .sect_wp_n_o  (sect_wp_n_o),
  .rdp_active_o (rdp_active_o),
  .user_opt_o   (user_opt_o),
  .locked_i     (locked),
  .dead_i       (key_dead)
);

// File: tb/opt_ctrl_tb.sv
module opt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 24;
  localparam int CC   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;
  logic [NSEC-1:0] wp_n;
  logic        rdp_act;
  logic [7:0]  user;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opt_ctrl #(.SECT_PER_REG(12), .DUAL_BANK(1'b1), .COMMIT_CYCLES(CC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .busy_o(busy),
    .sect_wp_n_o(wp_n), .rdp_active_o(rdp_act), .user_opt_o(user)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(2'd0, 32'h0819_2A3B);
    wr(2'd0, 32'h4C5D_6E7F);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd1, v); chk("R1 ctrl", v, 32'h0FFF_AAED);
    rd(2'd2, v); chk("R1 ctrl2", v, 32'h0FFF_0000);
    rd(2'd3, v); chk("R1 status", v, 32'h0);
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 wp", {8'b0, wp_n}, 32'h00FF_FFFF);
    chk("R1 rdp", {31'b0, rdp_act}, 32'h0);
    chk("R1 user", {24'b0, user}, 32'hEC);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wr(2'd1, 32'h0123_4570);
    rd(2'd1, v); chk("R4 ctrl ignored", v, 32'h0FFF_AAED);
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, v); chk("R4 ctrl2 ignored", v, 32'h0FFF_0000);
    wr(2'd1, 32'h0000_0002);
    chk("R4 no busy", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    unlock();
    rd(2'd1, v); chk("R2 unlocked", {31'b0, v[0]}, 32'h0);
  endtask

  task automatic t_stage();
    logic [31:0] v;
    wr(2'd1, 32'hFA5A_3370);
    rd(2'd1, v); chk("R5 ctrl stage", v, 32'h0A5A_3360);
    wr(2'd2, 32'hF3C3_FFFF);
    rd(2'd2, v); chk("R5 ctrl2 stage", v, 32'h03C3_0000);
    chk("R6 wp held", {8'b0, wp_n}, 32'h00FF_FFFF);
    chk("R6 rdp held", {31'b0, rdp_act}, 32'h0);
    chk("R6 user held", {24'b0, user}, 32'hEC);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    int cnt;
    wr(2'd1, 32'h0A5A_3362);
    #1 v = rdata;
    chk("R7 start bit reads 1", {31'b0, v[1]}, 32'h1);
    rd(2'd3, v); chk("R7 status busy", v, 32'h0001_0000);
    cnt = 2;
    for (int i = 0; i < 100 && busy; i++) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    chk("R7 busy cycles", cnt, CC);
    chk("R11 wp committed", {8'b0, wp_n}, 32'h003C_3A5A);
    chk("R9 rdp active", {31'b0, rdp_act}, 32'h1);
    chk("R7 user committed", {24'b0, user}, 32'h60);
    rd(2'd1, v); chk("R7 start cleared", v, 32'h0A5A_3360);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(2'd1, 32'h0FFF_AAEE);
    wr(2'd2, 32'h0000_0000);
    wr(2'd1, 32'h0000_0000);
    wait_idle();
    chk("R8 wp after busy writes", {8'b0, wp_n}, 32'h003C_3FFF);
    chk("R9 rdp open", {31'b0, rdp_act}, 32'h0);
    chk("R8 user", {24'b0, user}, 32'hEC);
    rd(2'd1, v); chk("R8 ctrl readback", v, 32'h0FFF_AAEC);
    rd(2'd2, v); chk("R8 ctrl2 readback", v, 32'h03C3_0000);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(2'd1, 32'h0FFF_AAEF);
    chk("R10 no commit", {31'b0, busy}, 32'h0);
    rd(2'd1, v); chk("R10 relocked", v, 32'h0FFF_AAED);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v); chk("R10 locked ignores", v, 32'h0FFF_AAED);
    unlock();
    rd(2'd1, v); chk("R10 reunlock", {31'b0, v[0]}, 32'h0);
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    do_reset();
    wr(2'd0, 32'h0819_2A3B);
    wr(2'd0, 32'h4C5D_6E7E);
    unlock();
    rd(2'd1, v); chk("R3 bad second key", {31'b0, v[0]}, 32'h1);
    wr(2'd1, 32'h0000_0002);
    chk("R3 no start", {31'b0, busy}, 32'h0);
    do_reset();
    wr(2'd0, 32'h1234_5678);
    unlock();
    rd(2'd1, v); chk("R3 bad first key", {31'b0, v[0]}, 32'h1);
    do_reset();
    unlock();
    rd(2'd1, v); chk("R3 reset clears bad key", {31'b0, v[0]}, 32'h0);
  endtask

  task automatic t_after_reset();
    do_reset();
    t_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_stage();
    t_commit();
    t_busy_ignore();
    t_relock();
    t_bad_key();
    t_after_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule